// File: doc/BRIEF.md
# Two-Channel Double-Buffered Serial Converter Input Port

This block is the digital front end of a two-channel serial-input digital-to-analog converter. Each channel has four pins of its own: an active-low frame sync, a serial clock, a data line and an active-low load strobe. A system clock samples all of these pins through synchronizers, and edges are detected synchronously. It must run at least four times faster than the serial clock.

While frame sync is low, a channel shifts in sixteen bits, most significant bit first, on falling serial clock edges. The low fourteen bits of that word go into the channel's input latch. The block output is a second register, the DAC latch, which holds the parallel 14-bit code. A falling edge on the load strobe copies the input latch into the DAC latch. If the strobe is held low, the copy happens by itself when the sixteenth bit completes the word.

Each channel has three named states:
- `ST_IDLE`: waiting for frame sync to fall.
- `ST_SHIFT`: collecting bits.
- `ST_FULL`: the word is complete and the channel waits for frame sync to rise.

The transitions are:
- frame start: `ST_IDLE` to `ST_SHIFT` on a frame sync fall.
- abort: `ST_SHIFT` to `ST_IDLE` on a frame sync rise before sixteen bits.
- word done: `ST_SHIFT` to `ST_FULL` on the sixteenth serial clock fall.
- frame end: `ST_FULL` to `ST_IDLE` on a frame sync rise.

Top module: `dual_dac_port`

## Requirements
- R1: After synchronous reset, every channel's input latch and DAC latch hold 0x2000 (midscale, offset binary), and every update pulse is low.
- R2: While frame sync is low, a data bit is taken on each serial clock falling edge, most significant bit first. Of the sixteen bits, the first two are dropped and the last fourteen form the code (bit 13 is the third bit received).
- R3: With the load strobe held low, the DAC latch takes the new code when the sixteenth bit is captured, and the update pulse is raised once.
- R4: With the load strobe high, a completed frame leaves the DAC latch and the update pulse unchanged. A later falling edge on the load strobe copies the input latch into the DAC latch, with one update pulse.
- R5: When frame sync rises before sixteen bits have been taken, the partial word is dropped and the input latch keeps its previous value.
- R6: Serial clock falls after the sixteenth within the same frame change nothing until frame sync rises.
- R7: When a load strobe falling edge and a word completion land in the same system clock cycle, the DAC latch is written once, with the new code, and gives a single update pulse.
- R8: The channels are independent: activity on one channel never changes another channel's code or update pulse.
- R9: The DAC latch changes only in a cycle where that channel's update pulse is high, and the pulse lasts one system clock cycle per transfer.
- R10: A load strobe falling edge, applied between system clock edges, appears on the DAC code after exactly the third system clock rising edge (two synchronizer flops plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous reset, active high |
| fs_n | input | NCH | Frame sync per channel, active low (bit 0 = A, bit 1 = B) |
| sclk | input | NCH | Serial clock per channel, data taken on falling edge |
| sdat | input | NCH | Serial data per channel |
| ld_n | input | NCH | Load strobe per channel, active low |
| dac_code | output | NCH*CODE_W | DAC latch codes, channel c at bits [c*CODE_W +: CODE_W] |
| dac_upd | output | NCH | One-cycle pulse per DAC latch write, per channel |

## Verification
Each pin change passes through two synchronizer flops and an edge-detect compare before it reaches a registered output. A transfer therefore shows on `dac_code` and `dac_upd` on the third system clock edge after the pin moves. The R10 check measures this exactly: one sample after two edges must still show the old code, and the next sample must show the new one. All other checks sample several system clocks after the last pin activity of a frame, so they fall after any transfer has settled. Update pulses are counted on every falling system clock edge, which lets each check compare the exact number of writes a stimulus caused on each channel.

// File: rtl/dacport_pkg.sv
package dacport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= {W{RST_VAL}};
        end else begin
            stage_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/dsp_chan.sv
module dsp_chan
    import dacport_pkg::*;
#(
    parameter int FRAME  = 16,
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fs_s,
    input  logic              sclk_s,
    input  logic              sd_s,
    input  logic              ld_s,
    output logic [CODE_W-1:0] code,
    output logic              upd
);
    localparam int CNT_W = $clog2(FRAME);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(FRAME - 1);

    rx_state_t         state_q, state_d;
    logic              fs_p, sclk_p, ld_p;
    logic [CNT_W-1:0]  cnt_q;
    logic [FRAME-1:0]  shift_q;
    logic [FRAME-1:0]  word_full;
    logic [CODE_W-1:0] in_q, dac_q, new_code, src_code;
    logic              upd_q;
    logic              fs_fall, fs_rise, sclk_fall, ld_fall;
    logic              bit_take, word_done, xfer;

    // previous samples for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            fs_p   <= 1'b1;
            sclk_p <= 1'b1;
            ld_p   <= 1'b1;
        end else begin
            fs_p   <= fs_s;
            sclk_p <= sclk_s;
            ld_p   <= ld_s;
        end
    end

    assign fs_fall   = fs_p & ~fs_s;
    assign fs_rise   = ~fs_p & fs_s;
    assign sclk_fall = sclk_p & ~sclk_s;
    assign ld_fall   = ld_p & ~ld_s;

    assign bit_take  = (state_q == ST_SHIFT) && sclk_fall && !fs_rise;
    assign word_done = bit_take && (cnt_q == LAST_BIT);
    assign word_full = {shift_q[FRAME-2:0], sd_s};
    assign new_code  = word_full[CODE_W-1:0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fs_fall) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (fs_rise)        state_d = ST_IDLE;
                else if (word_done) state_d = ST_FULL;
            end
            ST_FULL:  if (fs_rise) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register with bit counter and shifter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
            end else if (bit_take) begin
                shift_q <= word_full;
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // latch and output register
    assign xfer     = ld_fall || (word_done && !ld_s);
    assign src_code = word_done ? new_code : in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= MID_CODE;
            dac_q <= MID_CODE;
            upd_q <= 1'b0;
        end else begin
            if (word_done) in_q <= new_code;
            if (xfer)      dac_q <= src_code;
            upd_q <= xfer;
        end
    end

    assign code = dac_q;
    assign upd  = upd_q;

    // R3
    auto_load_chk: assert property (@(posedge clk) disable iff (rst)
        (word_done && !ld_s) |=> (upd_q && dac_q == $past(new_code)));

    // R4
    strobe_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_fall && !word_done) |=> (upd_q && dac_q == $past(in_q)));

    // R5
    abort_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT && fs_rise) |=> ($stable(in_q) && state_q == ST_IDLE));

    // R6
    extra_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FULL && sclk_fall) |=> $stable(in_q));

    // R9
    code_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_q) |-> upd_q);
endmodule

// File: rtl/dual_dac_port.sv
module dual_dac_port #(
    parameter int NCH    = 2,
    parameter int FRAME  = 16,
    parameter int CODE_W = 14
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        fs_n,
    input  logic [NCH-1:0]        sclk,
    input  logic [NCH-1:0]        sdat,
    input  logic [NCH-1:0]        ld_n,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [NCH-1:0]        dac_upd
);
    localparam int PINS = 4;
    localparam int SW   = PINS * NCH;

    logic [SW-1:0] pins_raw, pins_s;

    assign pins_raw = {ld_n, sdat, sclk, fs_n};

    dsp_sync #(.W(SW), .STAGES(2), .RST_VAL(1'b1)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .d_async (pins_raw),
        .d_sync  (pins_s)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dsp_chan #(.FRAME(FRAME), .CODE_W(CODE_W)) chan_i (
            .clk    (clk),
            .rst    (rst),
            .fs_s   (pins_s[c]),
            .sclk_s (pins_s[NCH + c]),
            .sd_s   (pins_s[2*NCH + c]),
            .ld_s   (pins_s[3*NCH + c]),
            .code   (dac_code[c*CODE_W +: CODE_W]),
            .upd    (dac_upd[c])
        );
    end
endmodule

// File: tb/dual_dac_port_tb.sv
`timescale 1ns/1ps
module dual_dac_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fs_n = 2'b11, sclk = 2'b11, sdat = 2'b00, ld_n = 2'b11;
    logic [27:0] dac_code;
    logic [1:0]  dac_upd;

    int total = 0, bad = 0;
    int pulses [2] = '{0, 0};
    logic [13:0] exp_code [2] = '{14'h2000, 14'h2000};
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_dac_port dut_i (
        .clk(clk), .rst(rst), .fs_n(fs_n), .sclk(sclk), .sdat(sdat),
        .ld_n(ld_n), .dac_code(dac_code), .dac_upd(dac_upd)
    );

    always @(negedge clk) begin
        for (int c = 0; c < 2; c++) if (!rst && dac_upd[c]) pulses[c]++;
    end

    // {channel, held-low strobe, word}
    localparam logic [17:0] VEC [6] = '{
        {1'b0, 1'b1, 16'h5A5A},
        {1'b1, 1'b1, 16'h0000},
        {1'b0, 1'b0, 16'hFFFF},
        {1'b1, 1'b0, 16'h2ACE},
        {1'b0, 1'b1, 16'h8001},
        {1'b1, 1'b0, 16'hC3FF}
    };

    function automatic logic [13:0] code_of(input int c);
        return dac_code[c*14 +: 14];
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input int c, input logic [15:0] w, input int nbits, input bit collide);
        fs_n[c] = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sdat[c] = (i < 16) ? w[15-i] : 1'b1;
            sclk[c] = 1'b1;
            wait_clk(4);
            sclk[c] = 1'b0;
            if (collide && i == 15) ld_n[c] = 1'b0;
            wait_clk(4);
        end
        sclk[c] = 1'b1;
        wait_clk(4);
        fs_n[c] = 1'b1;
        wait_clk(8);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int p0, p1, oc;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset values
        chk("R1 code A", code_of(0), 14'h2000);
        chk("R1 code B", code_of(1), 14'h2000);
        chk("R1 upd", dac_upd, 0);

        // R2 R3 R4 R8 table walk
        for (int v = 0; v < 6; v++) begin
            int c = VEC[v][17];
            int o = 1 - c;
            bit auto_m = VEC[v][16];
            logic [15:0] w = VEC[v][15:0];
            ld_n[c] = auto_m ? 1'b0 : 1'b1;
            wait_clk(8);
            p0 = pulses[c]; p1 = pulses[o];
            oc = code_of(o);
            send_frame(c, w, 16, 1'b0);
            if (auto_m) begin
                chk("R3 auto code", code_of(c), w[13:0]);
                chk("R3 auto pulses", pulses[c] - p0, 1);
            end else begin
                chk("R4 held code", code_of(c), exp_code[c]);
                chk("R4 held pulses", pulses[c] - p0, 0);
                ld_n[c] = 1'b0;
                wait_clk(8);
                chk("R2 strobe code", code_of(c), w[13:0]);
                chk("R4 strobe pulses", pulses[c] - p0, 1);
            end
            chk("R8 other code", code_of(o), oc);
            chk("R8 other pulses", pulses[o] - p1, 0);
            exp_code[c] = w[13:0];
            ld_n[c] = 1'b1;
            wait_clk(8);
        end

        // R10 latency of a strobe edge
        send_frame(1, 16'h1234, 16, 1'b0);
        ld_n[1] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R10 before third edge", code_of(1), exp_code[1]);
        @(posedge clk);
        @(negedge clk);
        chk("R10 at third edge", code_of(1), 14'h1234);
        chk("R9 single pulse", dac_upd[1], 1);
        @(negedge clk);
        chk("R9 pulse ends", dac_upd[1], 0);
        ld_n[1] = 1'b1;
        wait_clk(8);

        // R5 aborted frame keeps the previous input latch
        send_frame(0, 16'h0ABC, 16, 1'b0);
        send_frame(0, 16'hFFFF, 9, 1'b0);
        p0 = pulses[0];
        ld_n[0] = 1'b0;
        wait_clk(8);
        chk("R5 abort keeps word", code_of(0), 14'h0ABC);
        chk("R5 one pulse", pulses[0] - p0, 1);
        ld_n[0] = 1'b1;
        wait_clk(8);

        // R6 surplus clocks in one frame
        ld_n[0] = 1'b0;
        wait_clk(8);
        p0 = pulses[0];
        send_frame(0, 16'h1555, 19, 1'b0);
        chk("R6 surplus code", code_of(0), 14'h1555);
        chk("R6 surplus pulses", pulses[0] - p0, 1);
        ld_n[0] = 1'b1;
        wait_clk(8);

        // R7 strobe edge together with word completion
        p0 = pulses[1];
        send_frame(1, 16'h3E07, 16, 1'b1);
        chk("R7 collide code", code_of(1), 14'h3E07);
        chk("R7 collide pulses", pulses[1] - p0, 1);
        ld_n[1] = 1'b1;
        wait_clk(8);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule